// File: doc/BRIEF.md
# Trigger Pattern Event Detector

This block watches a trigger bus that is sampled on every clock and decides, sample by sample, whether the bus matches a programmed pattern. Each bit of the bus has its own condition. The low group of bits can react to edges, found by comparing each sample with the one before it. The high group of bits reacts only to levels. A whole-bus compare can also be programmed. It treats the level group as an unsigned number and checks it against a reference value.

An event counter counts the matching samples after an arm strobe. The event output rises when the programmed number of matches N has been reached, and it stays high until the next arm strobe. Before the first arm after reset, the block stays idle and counts nothing.

Top module: `trig_event_detector`

## Requirements
- R1: A level bit (index EDGE_W and up) takes the 3-bit condition code 000 = must be 0, 001 = must be 1, or 010 = don't-care. Every other code (011..111) on a level bit acts as don't-care.
- R2: An edge bit (index below EDGE_W) also takes 011 = rising (previous sample 0, current sample 1), 100 = falling (previous 1, current 0) and 101 = either edge (previous differs from current). Codes 110 and 111 act as don't-care. The previous sample is the bus value at the prior clock edge.
- R3: A sample matches only when every per-bit condition holds and the whole-bus compare holds.
- R4: Compare operator 001 requires the level group (as an unsigned number) to equal the reference. Operator 010 requires it to differ from the reference. Operators 000 and 111 disable the compare (it always holds).
- R5: With HAS_MAG=1, operators 011, 100, 101 and 110 require value > ref, value >= ref, value < ref and value <= ref. With HAS_MAG=0, these four operators disable the compare.
- R6: After an arm, eventOut is high in the cycle that follows the clock edge that sampled the Nth matching sample, and low before that.
- R7: A programmed N of 0 behaves as N = 1. N takes the low CNT_W bits of the written data, so the largest N is 2^CNT_W-1.
- R8: Once high, eventOut stays high through any bus activity until an arm strobe. An arm strobe clears the match count and eventOut at the next edge. A sample that coincides with the arm strobe is not counted.
- R9: After reset, eventOut is low and stays low until an arm strobe, whatever the bus does. Reset sets all conditions to don't-care, the operator to 000 and N to 1.
- R10: A write with cfgWe high programs one register chosen by cfgAddr. Address i < BUS_W loads bit i's condition from cfgWdata[2:0]. Address BUS_W loads the reference, BUS_W+1 loads the operator from cfgWdata[2:0], and BUS_W+2 loads N. Writes to any other address change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| trigBus | input | EDGE_W+LEVEL_W | Sampled trigger bus; the edge group sits in the low bits |
| cfgWe | input | 1 | Configuration write enable |
| cfgAddr | input | ADDR_W | Configuration register select |
| cfgWdata | input | DATA_W | Configuration write data |
| armStb | input | 1 | Clears the count and event, and starts counting |
| eventOut | output | 1 | Registered, sticky event flag |

## Verification
Two functions can act in the same cycle: the arm strobe and a matching sample. The bench provokes this by asserting arm while the bus holds a matching value, with N = 2. It then requires two further matches before the event rises, which shows that the coincident sample was dropped rather than counted. A second collision comes from rewriting N in the middle of a run. The bench also writes to unused addresses between arm and the matches, and judges the result by whether the event fires at exactly the expected match.

// File: rtl/trig_event_pkg.sv
package trig_event_pkg;
  localparam logic [2:0] CondZero = 3'b000;
  localparam logic [2:0] CondOne  = 3'b001;
  localparam logic [2:0] CondAny  = 3'b010;
  localparam logic [2:0] CondRise = 3'b011;
  localparam logic [2:0] CondFall = 3'b100;
  localparam logic [2:0] CondBoth = 3'b101;

  localparam logic [2:0] CmpOff = 3'b000;
  localparam logic [2:0] CmpEq  = 3'b001;
  localparam logic [2:0] CmpNe  = 3'b010;
  localparam logic [2:0] CmpGt  = 3'b011;
  localparam logic [2:0] CmpGe  = 3'b100;
  localparam logic [2:0] CmpLt  = 3'b101;
  localparam logic [2:0] CmpLe  = 3'b110;

  typedef struct packed {
    logic cntClr;
    logic cntInc;
  } ctrlStrobe_t;

  typedef enum logic [1:0] {StIdle, StCount, StFired} ctrlState_e;
endpackage

// File: rtl/trig_event_dp.sv
module trig_event_dp
  import trig_event_pkg::*;
#(
  parameter int EDGE_W  = 4,
  parameter int LEVEL_W = 4,
  parameter int CNT_W   = 8,
  parameter bit HAS_MAG = 1'b1,
  parameter int DATA_W  = 16,
  parameter int ADDR_W  = 4
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic [EDGE_W+LEVEL_W-1:0]  trigBus,
  input  logic                       cfgWe,
  input  logic [ADDR_W-1:0]          cfgAddr,
  input  logic [DATA_W-1:0]          cfgWdata,
  input  ctrlStrobe_t                strb,
  output logic                       patMatch,
  output logic                       lastHit
);
  localparam int BUS_W    = EDGE_W + LEVEL_W;
  localparam int ADDR_REF = BUS_W;
  localparam int ADDR_OP  = BUS_W + 1;
  localparam int ADDR_N   = BUS_W + 2;

  logic [2:0]         condCode [BUS_W];
  logic [LEVEL_W-1:0] refVal;
  logic [2:0]         cmpOp;
  logic [BUS_W-1:0]   prevBus;
  logic [BUS_W-1:0]   bitOk;
  logic [LEVEL_W-1:0] levelVal;
  logic               cmpOk;

  assign levelVal = trigBus[BUS_W-1:EDGE_W];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < BUS_W; i++) condCode[i] <= CondAny;
      refVal  <= '0;
      cmpOp   <= CmpOff;
      prevBus <= '0;
    end else begin
      prevBus <= trigBus;
      if (cfgWe) begin
        for (int i = 0; i < BUS_W; i++)
          if (cfgAddr == ADDR_W'(i)) condCode[i] <= cfgWdata[2:0];
        if (cfgAddr == ADDR_W'(ADDR_REF)) refVal <= cfgWdata[LEVEL_W-1:0];
        if (cfgAddr == ADDR_W'(ADDR_OP))  cmpOp  <= cfgWdata[2:0];
      end
    end
  end

  for (genvar b = 0; b < BUS_W; b++) begin : gBit
    if (b < EDGE_W) begin : gEdge
      always_comb begin
        case (condCode[b])
          CondZero: bitOk[b] = ~trigBus[b];
          CondOne:  bitOk[b] = trigBus[b];
          CondRise: bitOk[b] = trigBus[b] & ~prevBus[b];
          CondFall: bitOk[b] = ~trigBus[b] & prevBus[b];
          CondBoth: bitOk[b] = trigBus[b] ^ prevBus[b];
          default:  bitOk[b] = 1'b1;
        endcase
      end
      assert_rise_gate_R2: assert property (@(posedge clk) disable iff (!rstN)
        (condCode[b] == CondRise && !(trigBus[b] && !prevBus[b])) |-> !patMatch);
    end else begin : gLevel
      always_comb begin
        case (condCode[b])
          CondZero: bitOk[b] = ~trigBus[b];
          CondOne:  bitOk[b] = trigBus[b];
          default:  bitOk[b] = 1'b1;
        endcase
      end
    end
  end

  if (HAS_MAG) begin : gMag
    always_comb begin
      case (cmpOp)
        CmpEq:   cmpOk = (levelVal == refVal);
        CmpNe:   cmpOk = (levelVal != refVal);
        CmpGt:   cmpOk = (levelVal >  refVal);
        CmpGe:   cmpOk = (levelVal >= refVal);
        CmpLt:   cmpOk = (levelVal <  refVal);
        CmpLe:   cmpOk = (levelVal <= refVal);
        default: cmpOk = 1'b1;
      endcase
    end
  end else begin : gNoMag
    always_comb begin
      case (cmpOp)
        CmpEq:   cmpOk = (levelVal == refVal);
        CmpNe:   cmpOk = (levelVal != refVal);
        default: cmpOk = 1'b1;
      endcase
    end
  end

  assign patMatch = (&bitOk) & cmpOk;

  assert_eq_gate_R4: assert property (@(posedge clk) disable iff (!rstN)
    (cmpOp == CmpEq && levelVal != refVal) |-> !patMatch);

  if (CNT_W > 0) begin : gCnt
    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] cfgN;
    logic [CNT_W-1:0] nEff;
    logic [CNT_W:0]   cntNext;

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        cnt  <= '0;
        cfgN <= CNT_W'(1);
      end else begin
        if (cfgWe && cfgAddr == ADDR_W'(ADDR_N)) cfgN <= cfgWdata[CNT_W-1:0];
        if (strb.cntClr)      cnt <= '0;
        else if (strb.cntInc) cnt <= cnt + CNT_W'(1);
      end
    end

    assign nEff    = (cfgN == '0) ? CNT_W'(1) : cfgN;
    assign cntNext = {1'b0, cnt} + (CNT_W+1)'(1);
    assign lastHit = (cntNext >= {1'b0, nEff});

    assert_clr_zero_R8: assert property (@(posedge clk) disable iff (!rstN)
      strb.cntClr |=> (cnt == '0));
  end else begin : gNoCnt
    assign lastHit = 1'b1;
  end
endmodule

// File: rtl/trig_event_ctrl.sv
module trig_event_ctrl
  import trig_event_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        armStb,
  input  logic        patMatch,
  input  logic        lastHit,
  output ctrlStrobe_t strb,
  output logic        eventOut
);
  ctrlState_e state, stateNext;

  always_comb begin
    stateNext = state;
    if (armStb) stateNext = StCount;
    else if (state == StCount && patMatch && lastHit) stateNext = StFired;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= StIdle;
    else       state <= stateNext;
  end

  assign strb.cntClr = armStb;
  assign strb.cntInc = (state == StCount) && patMatch && !armStb;
  assign eventOut    = (state == StFired);

  assert_event_sticky_R8: assert property (@(posedge clk) disable iff (!rstN)
    (eventOut && !armStb) |=> eventOut);
  assert_arm_clears_R8: assert property (@(posedge clk) disable iff (!rstN)
    armStb |=> !eventOut);
  assert_idle_quiet_R9: assert property (@(posedge clk) disable iff (!rstN)
    (state == StIdle && !armStb) |=> !eventOut);
  assert_fire_on_last_R6: assert property (@(posedge clk) disable iff (!rstN)
    (state == StCount && patMatch && lastHit && !armStb) |=> eventOut);
endmodule

// File: rtl/trig_event_detector.sv
module trig_event_detector
  import trig_event_pkg::*;
#(
  parameter int EDGE_W  = 4,
  parameter int LEVEL_W = 4,
  parameter int CNT_W   = 8,
  parameter bit HAS_MAG = 1'b1,
  parameter int DATA_W  = 16,
  parameter int ADDR_W  = 4
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic [EDGE_W+LEVEL_W-1:0] trigBus,
  input  logic                      cfgWe,
  input  logic [ADDR_W-1:0]         cfgAddr,
  input  logic [DATA_W-1:0]         cfgWdata,
  input  logic                      armStb,
  output logic                      eventOut
);
  ctrlStrobe_t strb;
  logic        patMatch;
  logic        lastHit;

  trig_event_dp #(
    .EDGE_W(EDGE_W), .LEVEL_W(LEVEL_W), .CNT_W(CNT_W),
    .HAS_MAG(HAS_MAG), .DATA_W(DATA_W), .ADDR_W(ADDR_W)
  ) dp_i (
    .clk(clk), .rstN(rstN), .trigBus(trigBus), .cfgWe(cfgWe),
    .cfgAddr(cfgAddr), .cfgWdata(cfgWdata), .strb(strb),
    .patMatch(patMatch), .lastHit(lastHit)
  );

  trig_event_ctrl ctrl_i (
    .clk(clk), .rstN(rstN), .armStb(armStb), .patMatch(patMatch),
    .lastHit(lastHit), .strb(strb), .eventOut(eventOut)
  );
endmodule

// File: tb/trig_event_detector_tb.sv
module trig_event_detector_tb_top;
  localparam int EDGE_W  = 2;
  localparam int LEVEL_W = 3;
  localparam int BUS_W   = EDGE_W + LEVEL_W;
  localparam int CNT_W   = 8;
  localparam int DATA_W  = 16;
  localparam int ADDR_W  = 4;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic [BUS_W-1:0]  trigBus = '0;
  logic              cfgWe = 1'b0;
  logic [ADDR_W-1:0] cfgAddr = '0;
  logic [DATA_W-1:0] cfgWdata = '0;
  logic              armStb = 1'b0;
  logic              eventOut;

  int checks = 0;
  int fails  = 0;

  always #10 clk = ~clk;

  trig_event_detector #(
    .EDGE_W(EDGE_W), .LEVEL_W(LEVEL_W), .CNT_W(CNT_W),
    .HAS_MAG(1'b1), .DATA_W(DATA_W), .ADDR_W(ADDR_W)
  ) dut_i (
    .clk(clk), .rstN(rstN), .trigBus(trigBus), .cfgWe(cfgWe),
    .cfgAddr(cfgAddr), .cfgWdata(cfgWdata), .armStb(armStb),
    .eventOut(eventOut)
  );

  function automatic bit expCond(int code, bit isEdge, bit p, bit c);
    case (code)
      0: return !c;
      1: return c;
      3: return isEdge ? (!p && c) : 1'b1;
      4: return isEdge ? (p && !c) : 1'b1;
      5: return isEdge ? (p != c) : 1'b1;
      default: return 1'b1;
    endcase
  endfunction

  function automatic bit expCmp(int op, int v, int r);
    case (op)
      1: return v == r;
      2: return v != r;
      3: return v > r;
      4: return v >= r;
      5: return v < r;
      6: return v <= r;
      default: return 1'b1;
    endcase
  endfunction

  task automatic chk(string req, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: eventOut got %0b expected %0b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic cfgWrite(int addr, int data);
    cfgWe = 1'b1; cfgAddr = ADDR_W'(addr); cfgWdata = DATA_W'(data);
    @(posedge clk); @(negedge clk);
    cfgWe = 1'b0;
  endtask

  task automatic step(logic [BUS_W-1:0] bus, bit arm);
    trigBus = bus; armStb = arm;
    @(posedge clk); @(negedge clk);
    armStb = 1'b0;
  endtask

  localparam logic [BUS_W-1:0] MATCH_BUS = BUS_W'(5 << EDGE_W);
  localparam logic [BUS_W-1:0] MISS_BUS  = '0;

  initial begin
    @(negedge clk);
    chk("R9 reset", eventOut, 1'b0);
    @(negedge clk);
    rstN = 1'b1;
    // R9: idle until armed, even though defaults match every sample
    for (int i = 0; i < 5; i++) begin
      step(BUS_W'(i * 7), 1'b0);
      chk("R9 idle before arm", eventOut, 1'b0);
    end
    step('0, 1'b1);
    chk("R8 arm clears", eventOut, 1'b0);
    step(BUS_W'(13), 1'b0);
    chk("R9 default N=1 and don't-care", eventOut, 1'b1);

    // R1 R2 R3: per-bit condition sweep
    for (int b = 0; b < BUS_W; b++) begin
      for (int code = 0; code < 8; code++) begin
        cfgWrite(b, code);
        for (int p = 0; p < 2; p++) begin
          for (int c = 0; c < 2; c++) begin
            logic [BUS_W-1:0] other;
            logic [BUS_W-1:0] pv;
            logic [BUS_W-1:0] cv;
            other = BUS_W'(code * 7 + c * 3 + p);
            pv = other; pv[b] = p[0];
            cv = other; cv[b] = c[0];
            step(pv, 1'b1);
            step(cv, 1'b0);
            if (b < EDGE_W) chk("R2 edge bit condition", eventOut, expCond(code, 1'b1, p[0], c[0]));
            else            chk("R1 level bit condition", eventOut, expCond(code, 1'b0, p[0], c[0]));
          end
        end
      end
      cfgWrite(b, 2);
    end

    // R3: two conditions must hold together
    cfgWrite(0, 1);
    cfgWrite(EDGE_W, 0);
    step('0, 1'b1); step(BUS_W'(1), 1'b0);
    chk("R3 all bits hold", eventOut, 1'b1);
    step('0, 1'b1); step(BUS_W'(1 | (1 << EDGE_W)), 1'b0);
    chk("R3 one bit fails", eventOut, 1'b0);
    cfgWrite(0, 2); cfgWrite(EDGE_W, 2);

    // R4 R5: compare sweep
    for (int ri = 0; ri < 3; ri++) begin
      int r;
      r = (ri == 0) ? 0 : ((ri == 1) ? 3 : 7);
      cfgWrite(BUS_W, r);
      for (int op = 0; op < 8; op++) begin
        cfgWrite(BUS_W + 1, op);
        for (int v = 0; v < 8; v++) begin
          step(BUS_W'(3), 1'b1);
          step(BUS_W'((v << EDGE_W) | (v & 3)), 1'b0);
          if (op >= 3 && op <= 6) chk("R5 magnitude compare", eventOut, expCmp(op, v, r));
          else                    chk("R4 equality compare", eventOut, expCmp(op, v, r));
        end
      end
    end

    // R3: per-bit and compare combined
    cfgWrite(BUS_W, 5); cfgWrite(BUS_W + 1, 1); cfgWrite(0, 0);
    step('0, 1'b1); step(MATCH_BUS | BUS_W'(1), 1'b0);
    chk("R3 compare ok but bit fails", eventOut, 1'b0);
    cfgWrite(0, 2);

    // R6 R7 R8: counting
    for (int ni = 0; ni < 6; ni++) begin
      int n;
      int nEff;
      case (ni)
        0: n = 0; 1: n = 1; 2: n = 2; 3: n = 3; 4: n = 7; default: n = 255;
      endcase
      nEff = (n == 0) ? 1 : n;
      cfgWrite(BUS_W + 2, n);
      step(MISS_BUS, 1'b1);
      for (int i = 1; i <= nEff; i++) begin
        step(MATCH_BUS, 1'b0);
        chk((n == 0) ? "R7 N zero as one" : "R6 Nth match", eventOut, i >= nEff);
        step(MISS_BUS, 1'b0);
        chk("R8 sticky across miss", eventOut, i >= nEff);
      end
      step(MATCH_BUS, 1'b0);
      chk("R8 sticky after extra match", eventOut, 1'b1);
    end

    // R8: arm and match in the same cycle
    cfgWrite(BUS_W + 2, 2);
    step(MATCH_BUS, 1'b1);
    chk("R8 arm clears with match", eventOut, 1'b0);
    step(MATCH_BUS, 1'b0);
    chk("R8 arm-cycle match not counted", eventOut, 1'b0);
    step(MATCH_BUS, 1'b0);
    chk("R8 second post-arm match fires", eventOut, 1'b1);

    // R7: N truncated to CNT_W bits
    cfgWrite(BUS_W + 2, 16'h0102);
    step(MISS_BUS, 1'b1);
    step(MATCH_BUS, 1'b0);
    chk("R7 truncated N first", eventOut, 1'b0);
    step(MATCH_BUS, 1'b0);
    chk("R7 truncated N second", eventOut, 1'b1);

    // R10: unused addresses change nothing
    cfgWrite(BUS_W + 2, 3);
    step(MISS_BUS, 1'b1);
    cfgWrite(BUS_W + 3, 1);
    cfgWrite(15, 0);
    step(MATCH_BUS, 1'b0);
    chk("R10 ignored write, match 1", eventOut, 1'b0);
    step(MATCH_BUS, 1'b0);
    chk("R10 ignored write, match 2", eventOut, 1'b0);
    step(MATCH_BUS, 1'b0);
    chk("R10 ignored write, match 3", eventOut, 1'b1);
    step(MISS_BUS, 1'b1);
    step(BUS_W'(6 << EDGE_W), 1'b0);
    chk("R10 ref kept after ignored write", eventOut, 1'b0);

    // R8: rewrite N mid-run
    cfgWrite(BUS_W + 2, 4);
    step(MISS_BUS, 1'b1);
    step(MATCH_BUS, 1'b0);
    step(MATCH_BUS, 1'b0);
    chk("R6 below N", eventOut, 1'b0);
    cfgWrite(BUS_W + 2, 3);
    step(MATCH_BUS, 1'b0);
    chk("R6 new N reached", eventOut, 1'b1);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: run did not end, got timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule